// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the three configuration dwords that announce message-signalled interrupts with a vector table to the host. It sits at a fixed dword position in a function's configuration space and answers dword-addressed reads. It accepts byte-enabled writes, and the only thing a write can change is the function-wide enable flag. The number of vectors is fixed when the block is elaborated. The next-capability pointer comes in from the surrounding capability chain.

The block also works out where the vector table and its pending-bit array sit. They go on top of an existing memory BAR, whose size and index arrive as inputs. The block reports the enlarged BAR size the function must then decode, and it flags BAR sizes too large to be doubled. It exports the enable state to the vector-table logic. While the feature is on, it holds the legacy wired interrupt output low.

Top module: `msix_cap_regs`

## Requirements
- R1: The header dword (capability dword 0) reads as byte 0 = 0x11, byte 1 = the next-pointer input, and bits 31:16 = control word. In the control word, bits 10:0 hold the vector count minus one, bit 15 holds the enable flag, and all other bits read as 0.
- R2: A write to the header dword with byte-enable bit 3 set loads write-data bit 31 into the enable flag. The new value appears on the enable output and in read bit 31 from the clock edge that takes the write.
- R3: Writes leave the block's state unchanged in three cases: a header write without byte-enable bit 3, any write to capability dwords 1 and 2, and any write outside the structure.
- R4: Capability dword 1 (table locator) reads as the table base ORed with the BAR index in bits 2:0. The table base is 0 for an original size of 0, one page for a nonzero size below one page, and the original size otherwise.
- R5: Capability dword 2 (pending-array locator) reads as the table base plus half a page (0x800), ORed with the same BAR index.
- R6: The enlarged BAR size output is one page for an original size of 0 and two pages for a nonzero size below one page. Otherwise it is twice the original size, carried on 33 bits so that 0x80000000 yields 0x1_0000_0000.
- R7: An original size above 0x80000000 raises the size-error output and forces the enlarged size to 0. A size of exactly 0x80000000 is accepted.
- R8: A read is claimed (hit high) only for the three dwords starting at the capability's dword position. An unclaimed read returns 0.
- R9: While the enable flag is set, the legacy interrupt output is held low. While it is clear, the output follows the legacy interrupt request input.
- R10: Reset clears the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dw_addr | input | 6 | Configuration dword address |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_hit | output | 1 | Read claimed by this block |
| cfg_rdata | output | 32 | Read data, 0 when not claimed |
| next_ptr_i | input | 8 | Next capability pointer |
| bar_index_i | input | 3 | Index of the BAR that holds the table |
| orig_bar_size_i | input | 32 | BAR size before the table is added |
| bar_size_o | output | 33 | Enlarged BAR size |
| size_err_o | output | 1 | Original BAR size too large |
| msix_en_o | output | 1 | Enable flag |
| intx_req_i | input | 1 | Legacy interrupt request from the function |
| intx_o | output | 1 | Gated legacy interrupt line |

## Verification
The hardest cases to reach are the writes that must be ignored. A write can target the enable dword with the top byte masked, or carry bit 31 set into a neighbouring dword or into one outside the structure. In each case the stimulus sends write data of all ones, so that a wrong decode would change state. The header is then read back through the scoreboard and the enable output is checked. The BAR sizing corners are driven straight onto the size input: zero, below a page, exactly 0x80000000, and just above it.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
  localparam logic [7:0] MSIX_CAP_ID = 8'h11;
  localparam int         CAP_DWORDS  = 3;
  localparam int         MAX_VECTORS = 2048;

  typedef enum logic [1:0] {
    DW_HDR   = 2'd0,
    DW_TABLE = 2'd1,
    DW_PBA   = 2'd2,
    DW_NONE  = 2'd3
  } cap_dw_e;
endpackage

// File: rtl/msix_bar_calc.sv
module msix_bar_calc #(
  parameter int PAGE_BYTES = 4096,
  parameter int BARW       = 32
) (
  input  logic [BARW-1:0] orig_size,
  input  logic [2:0]      bar_index,
  output logic [BARW-1:0] table_reg,
  output logic [BARW-1:0] pba_reg,
  output logic [BARW:0]   new_size,
  output logic            size_err
);
  localparam logic [BARW-1:0] PAGE_V  = BARW'(PAGE_BYTES);
  localparam logic [BARW-1:0] HALF_V  = BARW'(PAGE_BYTES / 2);
  localparam logic [BARW-1:0] LIMIT_V = BARW'(1) << (BARW - 1);

  logic [BARW-1:0] base;
  logic [BARW-1:0] bir_ext;

  assign bir_ext = BARW'(bar_index);

  always_comb begin
    size_err = (orig_size > LIMIT_V);
    if (orig_size == '0) begin
      base     = '0;
      new_size = {1'b0, PAGE_V};
    end else if (orig_size < PAGE_V) begin
      base     = PAGE_V;
      new_size = {PAGE_V, 1'b0};
    end else begin
      base     = orig_size;
      new_size = {orig_size, 1'b0};
    end
    if (size_err) new_size = '0;
    table_reg = base | bir_ext;
    pba_reg   = (base + HALF_V) | bir_ext;
  end
endmodule

// File: rtl/msix_en_ctrl.sv
module msix_en_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_wr,
  input  logic top_be,
  input  logic wbit,
  output logic en_o
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (hdr_wr && top_be) en_d = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R2
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_wr && top_be) |=> (en_q == $past(wbit)));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_wr && top_be) |=> $stable(en_q));
endmodule

// File: rtl/msix_cfg_rdmux.sv
module msix_cfg_rdmux
  import msix_cap_pkg::*;
#(
  parameter int             NUM_VEC = 4,
  parameter logic [5:0]     CAP_DW  = 6'h10
) (
  input  logic [5:0]  dw_addr,
  input  logic        rd,
  input  logic        en,
  input  logic [7:0]  next_ptr,
  input  logic [31:0] table_reg,
  input  logic [31:0] pba_reg,
  output cap_dw_e     sel,
  output logic        hit,
  output logic [31:0] rdata
);
  localparam logic [10:0] QSIZE = 11'(NUM_VEC - 1);

  logic [5:0]  rel;
  logic [15:0] ctrl_word;

  assign rel       = dw_addr - CAP_DW;
  assign ctrl_word = {en, 4'b0000, QSIZE};

  always_comb begin
    if (rel < 6'(CAP_DWORDS)) sel = cap_dw_e'(rel[1:0]);
    else                      sel = DW_NONE;
  end

  always_comb begin
    hit   = rd && (sel != DW_NONE);
    rdata = '0;
    if (hit) begin
      case (sel)
        DW_HDR:   rdata = {ctrl_word, next_ptr, MSIX_CAP_ID};
        DW_TABLE: rdata = table_reg;
        DW_PBA:   rdata = pba_reg;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int         NUM_VEC    = 4,
  parameter logic [5:0] CAP_DW     = 6'h10,
  parameter int         PAGE_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cfg_dw_addr,
  input  logic        cfg_rd,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic        cfg_hit,
  output logic [31:0] cfg_rdata,
  input  logic [7:0]  next_ptr_i,
  input  logic [2:0]  bar_index_i,
  input  logic [31:0] orig_bar_size_i,
  output logic [32:0] bar_size_o,
  output logic        size_err_o,
  output logic        msix_en_o,
  input  logic        intx_req_i,
  output logic        intx_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [31:0] table_reg, pba_reg;
  cap_dw_e     sel;
  logic        hdr_wr;
  logic        unused_bits;

  assign unused_bits = ^{cfg_wdata[30:0], cfg_be[2:0]};

  msix_bar_calc #(.PAGE_BYTES(PAGE_BYTES), .BARW(32)) u_bar (
    .orig_size (orig_bar_size_i),
    .bar_index (bar_index_i),
    .table_reg (table_reg),
    .pba_reg   (pba_reg),
    .new_size  (bar_size_o),
    .size_err  (size_err_o)
  );

  msix_cfg_rdmux #(.NUM_VEC(NUM_VEC), .CAP_DW(CAP_DW)) u_rd (
    .dw_addr   (cfg_dw_addr),
    .rd        (cfg_rd),
    .en        (msix_en_o),
    .next_ptr  (next_ptr_i),
    .table_reg (table_reg),
    .pba_reg   (pba_reg),
    .sel       (sel),
    .hit       (cfg_hit),
    .rdata     (cfg_rdata)
  );

  assign hdr_wr = cfg_wr && (sel == DW_HDR);

  msix_en_ctrl u_en (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .hdr_wr (hdr_wr),
    .top_be (cfg_be[3]),
    .wbit   (cfg_wdata[31]),
    .en_o   (msix_en_o)
  );

  assign intx_o = intx_req_i && !msix_en_o;

  // R9
  intx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    msix_en_o |-> !intx_o);

  // R7
  size_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    size_err_o |-> (bar_size_o == '0));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cfg_hit |-> (cfg_rdata == '0));

  // R4
  table_bir_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cfg_hit && sel == DW_TABLE) |-> (cfg_rdata[2:0] == bar_index_i));

  // R6
  size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !size_err_o |-> (bar_size_o >= 33'(PAGE_BYTES)));
endmodule

// File: tb/msix_cap_regs_tb.sv
`timescale 1ns/1ps
module msix_cap_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_dw_addr = '0;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_hit;
  logic [31:0] cfg_rdata;
  logic [7:0]  next_ptr_i = 8'h50;
  logic [2:0]  bar_index_i = 3'd2;
  logic [31:0] orig_bar_size_i = '0;
  logic [32:0] bar_size_o;
  logic        size_err_o, msix_en_o;
  logic        intx_req_i = 1'b0;
  logic        intx_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] data;
    logic        hit;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #10 clk = ~clk;

  msix_cap_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dw_addr(cfg_dw_addr), .cfg_rd(cfg_rd),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata), .next_ptr_i(next_ptr_i),
    .bar_index_i(bar_index_i), .orig_bar_size_i(orig_bar_size_i),
    .bar_size_o(bar_size_o), .size_err_o(size_err_o), .msix_en_o(msix_en_o),
    .intx_req_i(intx_req_i), .intx_o(intx_o)
  );

  // Monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (cfg_rd) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: got %h", cfg_rdata);
      end else begin
        rd_item_t e;
        e = exp_q.pop_front();
        if (cfg_hit !== e.hit || cfg_rdata !== e.data) begin
          n_fail++;
          $display("FAIL %s: got hit=%b data=%h, expected hit=%b data=%h",
                   e.tag, cfg_hit, cfg_rdata, e.hit, e.data);
        end
      end
    end
  end

  task automatic do_read(input logic [5:0] a, input logic [31:0] d,
                         input logic h, input string tag);
    rd_item_t e;
    e.data = d; e.hit = h; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    cfg_dw_addr = a; cfg_rd = 1'b1;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [3:0] be,
                          input logic [31:0] d);
    @(posedge clk); #1;
    cfg_dw_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_bar(input logic [31:0] sz, input logic [2:0] bir);
    @(posedge clk); #1;
    orig_bar_size_i = sz; bar_index_i = bir;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10 / R1: reset state
    check("R10 enable after reset", 64'(msix_en_o), 64'd0);
    do_read(6'h10, 32'h0003_5011, 1'b1, "R1 header after reset");

    // R9: legacy line follows request while disabled
    intx_req_i = 1'b1; #1;
    check("R9 intx passes when disabled", 64'(intx_o), 64'd1);

    // R4 R5 R6: zero-size BAR
    set_bar(32'h0, 3'd2);
    check("R6 size for zero BAR", 64'(bar_size_o), 64'h1000);
    do_read(6'h11, 32'h0000_0002, 1'b1, "R4 table for zero BAR");
    do_read(6'h12, 32'h0000_0802, 1'b1, "R5 pba for zero BAR");

    // below one page
    set_bar(32'h100, 3'd2);
    check("R6 size for small BAR", 64'(bar_size_o), 64'h2000);
    do_read(6'h11, 32'h0000_1002, 1'b1, "R4 table for small BAR");
    do_read(6'h12, 32'h0000_1802, 1'b1, "R5 pba for small BAR");

    // large BAR
    set_bar(32'h0001_0000, 3'd5);
    check("R6 size for large BAR", 64'(bar_size_o), 64'h2_0000);
    do_read(6'h11, 32'h0001_0005, 1'b1, "R4 table for large BAR");
    do_read(6'h12, 32'h0001_0805, 1'b1, "R5 pba for large BAR");

    // R7 boundaries
    set_bar(32'h8000_0000, 3'd1);
    check("R7 limit size accepted err", 64'(size_err_o), 64'd0);
    check("R6 limit size doubled", 64'(bar_size_o), 64'h1_0000_0000);
    set_bar(32'h8000_1000, 3'd1);
    check("R7 oversize err", 64'(size_err_o), 64'd1);
    check("R7 oversize size", 64'(bar_size_o), 64'd0);
    set_bar(32'h0, 3'd2);

    // R3: ignored writes
    do_write(6'h10, 4'b0111, 32'hFFFF_FFFF);
    check("R3 masked top byte keeps enable", 64'(msix_en_o), 64'd0);
    do_read(6'h10, 32'h0003_5011, 1'b1, "R3 header after masked write");
    do_write(6'h11, 4'b1111, 32'hFFFF_FFFF);
    do_write(6'h12, 4'b1111, 32'hFFFF_FFFF);
    do_read(6'h11, 32'h0000_0002, 1'b1, "R3 table after write");
    do_read(6'h12, 32'h0000_0802, 1'b1, "R3 pba after write");
    do_write(6'h13, 4'b1111, 32'hFFFF_FFFF);
    check("R3 outside write keeps enable", 64'(msix_en_o), 64'd0);

    // R2 / R9: enable through the top byte only
    do_write(6'h10, 4'b1000, 32'h8000_0000);
    check("R2 enable set", 64'(msix_en_o), 64'd1);
    check("R9 intx held low when enabled", 64'(intx_o), 64'd0);
    do_read(6'h10, 32'h8003_5011, 1'b1, "R2 header shows enable");
    do_write(6'h10, 4'b1000, 32'h0000_0000);
    check("R2 enable cleared", 64'(msix_en_o), 64'd0);
    check("R9 intx returns after disable", 64'(intx_o), 64'd1);

    // R8: unclaimed reads
    do_read(6'h13, 32'h0, 1'b0, "R8 dword after structure");
    do_read(6'h0F, 32'h0, 1'b0, "R8 dword before structure");

    // R10: reset clears a set enable
    do_write(6'h10, 4'b1000, 32'h8000_0000);
    check("R2 enable set again", 64'(msix_en_o), 64'd1);
    @(posedge clk); #1 rst_n = 1'b0;
    #5;
    check("R10 reset clears enable", 64'(msix_en_o), 64'd0);
    #5 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    do_read(6'h10, 32'h0003_5011, 1'b1, "R10 header after reset");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: %0d reads not observed, expected 0", exp_q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule